// File: doc/BRIEF.md
# Burst-of-Two Quad-Data-Rate SRAM Core

This block is a synchronous static memory with independent read and write ports. The two ports share one address bus, which is split by clock phase. A read is requested on the rising edge of the input clock K and takes its address on that same edge. A write is requested on the rising edge of K, and its address arrives on the following falling edge of K, which stands in for the rising edge of the complementary clock K#. Both ports can start an access on every K cycle.

Every access moves a fixed burst of two 36-bit words. Storage is split into two sub-arrays that share the same word address: beat 0 lives in sub-array 0 and beat 1 in sub-array 1. Write data and the four active-low byte-write selects are taken on both halves of K. Read data is returned on both halves of the output clock. With `SINGLE_CLK=1` the output clock is K; with `SINGLE_CLK=0` it is the separate output clock input, which must then be phase-aligned with K.

The output drivers are modelled by an output-valid flag `oe_o` in place of a tri-state pad. The array depth is a parameter, so the core can be synthesized without any external memory model.

Top module: `qdr_b2_sram`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first read beat, `oe_o` is 0.
- R2: If `rps_ni` is low at a rising K edge, that edge captures `addr_i` as the read address. Beat 0 of the read is driven on `q_o` with `oe_o`=1 from the falling K edge 1.5 cycles later. Beat 1 follows from the next rising K edge.
- R3: If `wps_ni` is low at a rising K edge, that edge captures beat 0 data and beat 0 selects. The following falling K edge captures the write address, beat 1 data and beat 1 selects.
- R4: `bws_ni[i]` low writes bits 9i+8..9i of its beat; for example, `bws_ni[0]` guards bits 8:0 and `bws_ni[3]` guards bits 35:27. A lane whose select is high keeps its stored value.
- R5: While `wps_ni` is high at a rising K edge, the values on `addr_i`, `d_i` and `bws_ni` during that cycle change no stored word.
- R6: When no read was requested two cycles earlier, `oe_o` is 0 in both halves of the cycle after the previous burst completes.
- R7: Reads requested on consecutive K cycles produce a gap-free stream of beats, with `oe_o` held at 1 throughout.
- R8: The collision rule between reads and writes is fixed. A read issued in cycle n sees in beat 0 every write issued in cycle n or earlier. In beat 1 it also sees a write issued in cycle n+1. Beat 0 does not see a write issued in cycle n+1.
- R9: Beat 0 of a burst is read from, and written to, sub-array 0 at the burst address. Beat 1 uses sub-array 1 at the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock K; the falling edge acts as K# |
| c_clk_i | input | 1 | Output clock, used when SINGLE_CLK=0 |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rps_ni | input | 1 | Read port select, active low |
| wps_ni | input | 1 | Write port select, active low |
| addr_i | input | ADDR_W | Shared address: read address on the rising edge, write address on the falling edge |
| d_i | input | 36 | Write data, one beat per clock half |
| bws_ni | input | 4 | Byte-write selects, active low, one per 9-bit lane |
| q_o | output | 36 | Read data, one beat per output clock half |
| oe_o | output | 1 | High while `q_o` carries a valid read beat |

## Verification
Three properties are checked on every cycle. Lane masking is checked against the previous contents of the addressed word, in both sub-arrays. The absence of any array change while the write port is idle is checked every cycle. The fixed three-edge distance from a read select to the rising-half output flag is also checked every cycle. The following can only be shown by the bench scenarios, which compare both output halves of every cycle against a behavioural model:
- beat ordering across the two sub-arrays;
- the exact collision rule between a read and a write one cycle later;
- gap-free back-to-back reads;
- values returned after writes with mixed lane masks.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int LANE_W = 9;
  localparam int BEATS  = 2;
endpackage

// File: rtl/qdr_wr_path.sv
module qdr_wr_path #(
  parameter int DATA_W = 36,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wps_ni,
  input  logic [DATA_W-1:0] d_i,
  input  logic [LANES-1:0]  bws_ni,
  output logic              wr_go_o,
  output logic [DATA_W-1:0] d0_o,
  output logic [LANES-1:0]  be0_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_go_o <= 1'b0;
    else         wr_go_o <= !wps_ni;
  end

  // beat 0 held until the falling-edge commit
  always_ff @(posedge clk_i) begin
    d0_o  <= d_i;
    be0_o <= ~bws_ni;
  end
endmodule

// File: rtl/qdr_bank.sv
module qdr_bank import qdr_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [LANES-1:0]        wbe_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] keep_mask;

  always_comb begin
    for (int l = 0; l < LANES; l++)
      keep_mask[l*LANE_W +: LANE_W] = {LANE_W{~wbe_i[l]}};
  end

  always_ff @(negedge clk_i) begin
    if (we_i) begin
      for (int l = 0; l < LANES; l++)
        if (wbe_i[l]) mem[waddr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
    end
  end

  assign rdata_o = mem[raddr_i];

  assert_lane_hold_R4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (we_i && !$isunknown(mem[waddr_i])) |=>
      (((mem[$past(waddr_i)] ^ $past(mem[waddr_i])) & $past(keep_mask)) == '0));

  assert_idle_hold_R5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!we_i && !$isunknown(mem[waddr_i])) |=> (mem[$past(waddr_i)] == $past(mem[waddr_i])));
endmodule

// File: rtl/qdr_rd_path.sv
module qdr_rd_path #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 36,
  parameter bit SINGLE_CLK = 1'b1
) (
  input  logic              clk_i,
  input  logic              c_clk_i,
  input  logic              rst_ni,
  input  logic              rps_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] bank_addr_o,
  input  logic [DATA_W-1:0] beat0_i,
  input  logic [DATA_W-1:0] beat1_i,
  output logic [DATA_W-1:0] q_o,
  output logic              oe_o
);
  logic              out_clk;
  logic              rd_go, rd_go1;
  logic [ADDR_W-1:0] rd_addr, rd_a1;
  logic              oe_rise, oe_fall;
  logic [DATA_W-1:0] q_rise, q_fall;
  logic [1:0]        live_q;

  assign out_clk = SINGLE_CLK ? clk_i : c_clk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_go   <= 1'b0;
      rd_go1  <= 1'b0;
      rd_addr <= '0;
      rd_a1   <= '0;
    end else begin
      rd_go  <= !rps_ni;
      rd_go1 <= rd_go;
      rd_a1  <= rd_addr;
      if (!rps_ni) rd_addr <= addr_i;
    end
  end

  assign bank_addr_o = rd_a1;

  // beat 0 on the falling half, beat 1 on the next rising half
  always_ff @(negedge out_clk or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_fall <= 1'b0;
      q_fall  <= '0;
    end else begin
      oe_fall <= rd_go1;
      q_fall  <= beat0_i;
    end
  end

  always_ff @(posedge out_clk or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_rise <= 1'b0;
      q_rise  <= '0;
    end else begin
      oe_rise <= rd_go1;
      q_rise  <= beat1_i;
    end
  end

  assign q_o  = out_clk ? q_rise  : q_fall;
  assign oe_o = out_clk ? oe_rise : oe_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            live_q <= '0;
    else if (live_q != 2'd3) live_q <= live_q + 2'd1;
  end

  if (SINGLE_CLK) begin : g_chk
    assert_rd_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rps_ni |-> ##3 oe_rise);

    assert_rd_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q == 2'd3 && $past(rps_ni, 3)) |-> !oe_rise);
  end
endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram import qdr_pkg::*; #(
  parameter int ADDR_W     = 8,
  parameter int LANES      = 4,
  parameter bit SINGLE_CLK = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    c_clk_i,
  input  logic                    rst_ni,
  input  logic                    rps_ni,
  input  logic                    wps_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] d_i,
  input  logic [LANES-1:0]        bws_ni,
  output logic [LANES*LANE_W-1:0] q_o,
  output logic                    oe_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic              wr_go;
  logic [DATA_W-1:0] wd0;
  logic [LANES-1:0]  wbe0;
  logic [ADDR_W-1:0] rd_a;
  logic [DATA_W-1:0] bank_q [BEATS];

  qdr_wr_path #(.DATA_W(DATA_W), .LANES(LANES)) u_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wps_ni  (wps_ni),
    .d_i     (d_i),
    .bws_ni  (bws_ni),
    .wr_go_o (wr_go),
    .d0_o    (wd0),
    .be0_o   (wbe0)
  );

  for (genvar b = 0; b < BEATS; b++) begin : g_bank
    // bank 0 commits the held beat, bank 1 the live falling-edge beat
    qdr_bank #(.ADDR_W(ADDR_W), .LANES(LANES)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_go),
      .waddr_i (addr_i),
      .wdata_i ((b == 0) ? wd0  : d_i),
      .wbe_i   ((b == 0) ? wbe0 : ~bws_ni),
      .raddr_i (rd_a),
      .rdata_o (bank_q[b])
    );
  end

  qdr_rd_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SINGLE_CLK(SINGLE_CLK)) u_rd (
    .clk_i       (clk_i),
    .c_clk_i     (c_clk_i),
    .rst_ni      (rst_ni),
    .rps_ni      (rps_ni),
    .addr_i      (addr_i),
    .bank_addr_o (rd_a),
    .beat0_i     (bank_q[0]),
    .beat1_i     (bank_q[1]),
    .q_o         (q_o),
    .oe_o        (oe_o)
  );
endmodule

// File: tb/qdr_b2_sram_test.sv
module qdr_b2_sram_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 36;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, rps_n = 1'b1, wps_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d = '0;
  logic [3:0] bws_n = 4'hf;
  logic [DW-1:0] q;
  logic oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdr_b2_sram uut (
    .clk_i(clk), .c_clk_i(clk), .rst_ni(rst_n), .rps_ni(rps_n), .wps_ni(wps_n),
    .addr_i(addr), .d_i(d), .bws_ni(bws_n), .q_o(q), .oe_o(oe)
  );

  int checks = 0, fails = 0;
  string tag = "R1";
  bit run = 1'b0;
  bit done = 1'b0;

  // behavioural reference
  logic [DW-1:0] m0 [DEPTH];
  logic [DW-1:0] m1 [DEPTH];
  bit rv [3];
  logic [AW-1:0] ra [3];
  bit wr_pend = 1'b0;
  logic [DW-1:0] wd0;
  logic [3:0] wbn0;
  bit eo_r = 1'b0, eo_f = 1'b0;
  logic [DW-1:0] eq_r, eq_f;

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [3:0] bn);
    logic [DW-1:0] r = old;
    for (int l = 0; l < 4; l++) if (!bn[l]) r[l*9 +: 9] = nw[l*9 +: 9];
    return r;
  endfunction

  initial for (int i = 0; i < 3; i++) begin rv[i] = 1'b0; ra[i] = '0; end

  always @(posedge clk) begin
    rv[2] = rv[1]; ra[2] = ra[1];
    rv[1] = rv[0]; ra[1] = ra[0];
    rv[0] = rst_n && !rps_n; ra[0] = addr;
    eo_r = rv[2];
    eq_r = m1[ra[2]];
    wr_pend = rst_n && !wps_n; wd0 = d; wbn0 = bws_n;
  end

  always @(negedge clk) begin
    eo_f = rv[1];
    eq_f = m0[ra[1]];
    if (wr_pend) begin
      m0[addr] = merge(m0[addr], wd0, wbn0);
      m1[addr] = merge(m1[addr], d, bws_n);
    end
  end

  task automatic check_half(bit e_oe, logic [DW-1:0] e_q, string beat);
    checks++;
    if (oe !== e_oe) begin
      fails++;
      $display("FAIL %s %s oe: got %b expected %b", tag, beat, oe, e_oe);
    end else if (e_oe && q !== e_q) begin
      fails++;
      $display("FAIL %s %s data: got %h expected %h", tag, beat, q, e_q);
    end
  endtask

  always @(posedge clk) if (run) begin #3; check_half(eo_r, eq_r, "beat1"); end
  always @(negedge clk) if (run) begin #3; check_half(eo_f, eq_f, "beat0"); end

  task automatic cyc(bit rd, logic [AW-1:0] rda, bit wr, logic [AW-1:0] wra,
                     logic [DW-1:0] d0, logic [3:0] b0, logic [DW-1:0] d1, logic [3:0] b1);
    rps_n = !rd; wps_n = !wr;
    addr  = rd ? rda : AW'($urandom);
    d     = wr ? d0 : {4'($urandom), 32'($urandom)};
    bws_n = wr ? b0 : 4'($urandom);
    @(posedge clk); #1;
    addr  = wr ? wra : AW'($urandom);
    d     = wr ? d1 : {4'($urandom), 32'($urandom)};
    bws_n = wr ? b1 : 4'($urandom);
    @(negedge clk); #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, '0, '0, 4'hf, '0, 4'hf);
  endtask

  task automatic rd(logic [AW-1:0] a);
    cyc(1'b1, a, 1'b0, '0, '0, 4'hf, '0, 4'hf);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d0, logic [3:0] b0, logic [DW-1:0] d1, logic [3:0] b1);
    cyc(1'b0, '0, 1'b1, a, d0, b0, d1, b1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    checks++;
    if (oe !== 1'b0) begin fails++; $display("FAIL R1 reset oe: got %b expected 0", oe); end
    rst_n = 1'b1;
    run = 1'b1;
    idle(2);

    // R9: distinct data per beat in each sub-array
    tag = "R9";
    for (int i = 0; i < DEPTH; i++)
      wr(AW'(i), {4'h5, 24'hA5A5A5, 8'(i)}, 4'h0, {4'hC, 24'h3C3C3C, 8'(~i)}, 4'h0);
    idle(2);

    // R2: isolated reads with gaps
    tag = "R2";
    for (int i = 0; i < 12; i++) begin rd(AW'(i * 37)); idle(1); end
    idle(3);

    // R7: back-to-back reads
    tag = "R7";
    for (int i = 0; i < 20; i++) rd(AW'($urandom));
    idle(3);

    // R3: random full writes, then readback
    tag = "R3";
    for (int i = 10; i < 20; i++)
      wr(AW'(i), {4'($urandom), 32'($urandom)}, 4'h0, {4'($urandom), 32'($urandom)}, 4'h0);
    for (int i = 10; i < 20; i++) rd(AW'(i));
    idle(3);

    // R4: lane masks per beat
    tag = "R4";
    wr(8'd30, 36'hF_FFFF_FFFF, 4'b1010, 36'h0_0000_0000, 4'b0101);
    wr(8'd31, 36'h1_2345_6789, 4'b0111, 36'h9_8765_4321, 4'b1110);
    wr(8'd32, 36'h0_0000_0000, 4'b1111, 36'h0_0000_0000, 4'b1111);
    wr(8'd33, 36'hA_BCDE_F012, 4'b0110, 36'h3_4567_89AB, 4'b1001);
    for (int i = 30; i < 34; i++) rd(AW'(i));
    idle(3);

    // R5: write port deselected with noise on the bus
    tag = "R5";
    for (int i = 0; i < 16; i++) idle(1);
    for (int i = 0; i < 16; i++) rd(AW'(i + 28));
    idle(3);

    // R8: collisions
    tag = "R8";
    cyc(1'b1, 8'd50, 1'b1, 8'd50, 36'h1_1111_1111, 4'h0, 36'h2_2222_2222, 4'h0);
    idle(3);
    rd(8'd60);
    wr(8'd60, 36'h3_3333_3333, 4'h0, 36'h4_4444_4444, 4'h0);
    idle(3);
    rd(8'd61);
    idle(1);
    wr(8'd61, 36'h5_5555_5555, 4'h0, 36'h6_6666_6666, 4'h0);
    rd(8'd61);
    idle(3);

    // R6: single read then long deselect
    tag = "R6";
    rd(8'd5);
    idle(6);

    // full sweep of both sub-arrays
    tag = "R9";
    for (int i = 0; i < DEPTH; i++) rd(AW'(i));
    idle(4);

    done = 1'b1;
    run = 1'b0;
    summary();
    $finish;
  end
endmodule